// File: doc/BRIEF.md
# Windowed Program-ROM Bank Translator

This block turns a CPU address in the upper part of a 16-bit map into a byte address in a program ROM of up to 2 MB. The CPU space from 0x8000 to 0xFFFF is split into 8 KB windows. A 3-bit arrangement code in the control register groups those windows as one 32 KB bank, two 16 KB banks or four 8 KB banks. In half of the arrangements the bank holding the reset vectors is pinned to the last bank, and in the other half software can switch it. The window at 0x6000 to 0x7FFF can also be turned into a ROM window. Its bank is derived from bank register 3, so that it lines up with the bank size in use.

Software loads four bank registers, a control register and an outer-segment register through write strobes. A 2-bit outer segment number forms the top of the bank number. This lets the block reach four separate 512 KB segments. Translation is purely combinational from the stored registers. A register write is seen on the output from the clock edge that captures it.

The arrangement codes are named as follows: PM_32K_FIX (0), PM_16K_FIX (1), PM_8K_FIX (2), PM_8K_FIX_ALT (3), PM_32K_SW (4), PM_16K_SW (5), PM_8K_SW (6) and PM_8K_SW_ALT (7). There is no sequencing state. The arrangement code is the only mode selector.

Top module: `prgmap_top`

## Requirements
- R1: After reset, every bank register holds all ones, and the control and outer registers hold zero. So 0x8000 translates to 0x78000 and the 0x6000 window is not ROM.
- R2: An address below 0x6000 gives rom_sel=0 and rom_addr=0. Every address at 0x8000 or above gives rom_sel=1. Whenever rom_sel=1, rom_addr[12:0] equals cpu_addr[12:0].
- R3: Control bit 7 set makes 0x6000–0x7FFF a ROM window (rom_sel=1). low_win_rom always shows the stored control bit 7.
- R4: Codes 0 and 4 (32 KB). 0x8000–0xFFFF maps to a 32 KB bank, given by rom_addr[18:15]. That bank is 0xF under code 0 and bank register 3 bits [3:0] under code 4. cpu_addr[14:13] passes through to rom_addr[14:13].
- R5: Codes 1 and 5 (16 KB). 0x8000–0xBFFF uses bank register 1 bits [4:0] as rom_addr[18:14]. 0xC000–0xFFFF uses 0x1F under code 1 and bank register 3 bits [4:0] under code 5.
- R6: Codes 2, 3, 6 and 7 (8 KB). The windows at 0x8000, 0xA000 and 0xC000 use bank registers 0, 1 and 2, with bits [5:0] as rom_addr[18:13]. The window at 0xE000 uses 0x3F under codes 2 and 3, and bank register 3 under codes 6 and 7. Code 3 equals code 2, and code 7 equals code 6.
- R7: When it is mapped, the 0x6000 window uses these values for rom_addr[18:13]: {reg3[3:0],2'b11} in the 32 KB codes, {reg3[4:0],1'b1} in the 16 KB codes, and reg3[5:0] in the 8 KB codes.
- R8: Outer register bits [2:1] become rom_addr[20:19] for every ROM access. Its other bits have no effect.
- R9: A write with bank_wr=1 loads bank register wr_idx only. Control bits [6:3] have no effect on translation. Each write shows on the outputs from the clock edge that captures it.
- R10: When control bit 2 is clear, addresses 0xE000–0xFFFF always land in 8 KB bank 0x3F of the current outer segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Load bank register wr_idx |
| ctrl_wr | input | 1 | Load control register |
| outer_wr | input | 1 | Load outer-segment register |
| wr_idx | input | 2 | Bank register index |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 21 | ROM byte address (zero when not ROM) |
| rom_sel | output | 1 | Address maps to ROM |
| low_win_rom | output | 1 | 0x6000 window is ROM |

## Verification
An address change affects rom_addr and rom_sel in the same cycle, because no register lies on that path. The bench therefore drives cpu_addr just after a falling edge and samples 1 ns later. A register write needs one rising edge. Each write strobe is held from one falling edge to the next, so the stored value is settled before the following address is applied and checked. The directed write-routing checks also sample right after that edge, which confirms the single-edge latency.

// File: rtl/prgmap_pkg.sv
package prgmap_pkg;

    localparam int DATA_W    = 8;
    localparam int CPU_AW    = 16;
    localparam int OFF_W     = 13;
    localparam int SEG_W     = 2;
    localparam int LOW_W     = 6;
    localparam int BANK_W    = SEG_W + LOW_W;
    localparam int ROM_AW    = BANK_W + OFF_W;
    localparam int NUM_BANKS = 4;
    localparam int IDX_W     = $clog2(NUM_BANKS);

    typedef enum logic [2:0] {
        PM_32K_FIX    = 3'd0,
        PM_16K_FIX    = 3'd1,
        PM_8K_FIX     = 3'd2,
        PM_8K_FIX_ALT = 3'd3,
        PM_32K_SW     = 3'd4,
        PM_16K_SW     = 3'd5,
        PM_8K_SW      = 3'd6,
        PM_8K_SW_ALT  = 3'd7
    } prg_mode_e;

    typedef enum logic [1:0] {
        SZ_32K,
        SZ_16K,
        SZ_8K
    } bank_size_e;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_LOW,
        WIN_8,
        WIN_A,
        WIN_C,
        WIN_E
    } win_e;

endpackage

// File: rtl/prgmap_regs.sv
module prgmap_regs
    import prgmap_pkg::*;
#(
    parameter int NB   = NUM_BANKS,
    parameter int IW   = IDX_W,
    parameter int DW   = DATA_W,
    parameter int LW   = LOW_W,
    parameter int SW   = SEG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bank_wr,
    input  logic          ctrl_wr,
    input  logic          outer_wr,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [LW-1:0] bank_q [NB],
    output prg_mode_e     mode_q,
    output logic          low_rom_q,
    output logic [SW-1:0] seg_q
);

    // Only the low bits any arrangement reads are stored; reset is all ones.
    for (genvar i = 0; i < NB; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[i] <= '1;
            end else if (bank_wr && wr_idx == IW'(i)) begin
                bank_q[i] <= wr_data[LW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= PM_32K_FIX;
            low_rom_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q    <= prg_mode_e'(wr_data[2:0]);
            low_rom_q <= wr_data[DW-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (outer_wr) begin
            seg_q <= wr_data[SW:1];
        end
    end

endmodule

// File: rtl/prgmap_decode.sv
module prgmap_decode
    import prgmap_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int OW = OFF_W
) (
    input  logic [AW-1:0] cpu_addr,
    output win_e          win,
    output logic [OW-1:0] offset
);

    always_comb begin
        unique case (cpu_addr[AW-1:OW])
            3'b011:  win = WIN_LOW;
            3'b100:  win = WIN_8;
            3'b101:  win = WIN_A;
            3'b110:  win = WIN_C;
            3'b111:  win = WIN_E;
            default: win = WIN_NONE;
        endcase
    end

    assign offset = cpu_addr[OW-1:0];

endmodule

// File: rtl/prgmap_bank.sv
module prgmap_bank
    import prgmap_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int LW = LOW_W,
    parameter int SW = SEG_W
) (
    input  prg_mode_e     mode,
    input  win_e          win,
    input  logic [1:0]    sub,
    input  logic [LW-1:0] bank_q [NB],
    input  logic [SW-1:0] seg,
    output logic [SW+LW-1:0] bank8
);

    bank_size_e size;
    logic       swap_top;
    logic [LW-1:0] low;
    logic [3:0] b32;
    logic [4:0] b16;

    always_comb begin
        unique case (mode)
            PM_32K_FIX:                 begin size = SZ_32K; swap_top = 1'b0; end
            PM_32K_SW:                  begin size = SZ_32K; swap_top = 1'b1; end
            PM_16K_FIX:                 begin size = SZ_16K; swap_top = 1'b0; end
            PM_16K_SW:                  begin size = SZ_16K; swap_top = 1'b1; end
            PM_8K_FIX, PM_8K_FIX_ALT:   begin size = SZ_8K;  swap_top = 1'b0; end
            PM_8K_SW, PM_8K_SW_ALT:     begin size = SZ_8K;  swap_top = 1'b1; end
            default:                    begin size = SZ_8K;  swap_top = 1'b0; end
        endcase
    end

    always_comb begin
        b32 = swap_top ? bank_q[3][3:0] : 4'hF;
        b16 = (win == WIN_8 || win == WIN_A) ? bank_q[1][4:0]
            : (swap_top ? bank_q[3][4:0] : 5'h1F);
        low = '0;
        if (win == WIN_LOW) begin
            unique case (size)
                SZ_32K:  low = {bank_q[3][3:0], 2'b11};
                SZ_16K:  low = {bank_q[3][4:0], 1'b1};
                default: low = bank_q[3];
            endcase
        end else begin
            unique case (size)
                SZ_32K:  low = {b32, sub};
                SZ_16K:  low = {b16, sub[0]};
                default: begin
                    unique case (win)
                        WIN_8:   low = bank_q[0];
                        WIN_A:   low = bank_q[1];
                        WIN_C:   low = bank_q[2];
                        default: low = swap_top ? bank_q[3] : '1;
                    endcase
                end
            endcase
        end
    end

    assign bank8 = {seg, low};

endmodule

// File: rtl/prgmap_top.sv
module prgmap_top
    import prgmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr,
    input  logic              ctrl_wr,
    input  logic              outer_wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic              low_win_rom
);

    logic [LOW_W-1:0]  bank_q [NUM_BANKS];
    prg_mode_e         mode_q;
    logic              low_rom_q;
    logic [SEG_W-1:0]  seg_q;
    win_e              win;
    logic [OFF_W-1:0]  offset;
    logic [BANK_W-1:0] bank8;

    prgmap_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_wr   (bank_wr),
        .ctrl_wr   (ctrl_wr),
        .outer_wr  (outer_wr),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .bank_q    (bank_q),
        .mode_q    (mode_q),
        .low_rom_q (low_rom_q),
        .seg_q     (seg_q)
    );

    prgmap_decode u_dec (
        .cpu_addr (cpu_addr),
        .win      (win),
        .offset   (offset)
    );

    prgmap_bank u_bank (
        .mode   (mode_q),
        .win    (win),
        .sub    (cpu_addr[OFF_W+1:OFF_W]),
        .bank_q (bank_q),
        .seg    (seg_q),
        .bank8  (bank8)
    );

    always_comb begin
        rom_sel  = (win != WIN_NONE) && ((win != WIN_LOW) || low_rom_q);
        rom_addr = rom_sel ? {bank8, offset} : '0;
    end

    assign low_win_rom = low_rom_q;

endmodule

// File: rtl/prgmap_chk.sv
module prgmap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic        outer_wr,
    input logic        d_top,
    input logic        d_code2,
    input logic [1:0]  d_seg,
    input logic [15:0] cpu_addr,
    input logic [20:0] rom_addr,
    input logic        rom_sel,
    input logic        low_win_rom
);

    logic       sh_top;
    logic       sh_code2;
    logic [1:0] sh_seg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_top   <= 1'b0;
            sh_code2 <= 1'b0;
            sh_seg   <= 2'b00;
        end else begin
            if (ctrl_wr) begin
                sh_top   <= d_top;
                sh_code2 <= d_code2;
            end
            if (outer_wr) sh_seg <= d_seg;
        end
    end

    a_r2_unmapped_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!rom_sel && rom_addr == 21'h0));

    a_r2_upper_is_rom: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> rom_sel);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rom_addr[12:0] == cpu_addr[12:0]));

    a_r3_low_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b011) |-> (rom_sel == sh_top));

    a_r3_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        low_win_rom == sh_top);

    a_r8_outer_segment: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rom_addr[20:19] == sh_seg));

    a_r10_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_code2 && cpu_addr[15:13] == 3'b111) |-> (rom_addr[18:13] == 6'h3F));

endmodule

bind prgmap_top prgmap_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .outer_wr    (outer_wr),
    .d_top       (wr_data[7]),
    .d_code2     (wr_data[2]),
    .d_seg       (wr_data[2:1]),
    .cpu_addr    (cpu_addr),
    .rom_addr    (rom_addr),
    .rom_sel     (rom_sel),
    .low_win_rom (low_win_rom)
);

// File: tb/sim_prgmap_top.sv
`timescale 1ns/1ps
module sim_prgmap_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_wr = 1'b0, ctrl_wr = 1'b0, outer_wr = 1'b0;
    logic [1:0]  wr_idx = 2'd0;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] cpu_addr = 16'h0000;
    logic [20:0] rom_addr;
    logic        rom_sel, low_win_rom;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prgmap_top u0 (
        .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .ctrl_wr(ctrl_wr),
        .outer_wr(outer_wr), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .rom_addr(rom_addr), .rom_sel(rom_sel),
        .low_win_rom(low_win_rom)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  outer;
        logic [15:0] addr;
        logic [20:0] exp_addr;
        logic        exp_sel;
        logic [7:0]  req;
    } vec_t;

    // Bank registers during the table: r0=05 r1=2A r2=13 r3=37
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 16'h9234, 21'h79234, 1'b1, 8'd4},  // R4 fixed 32K
        '{8'h04, 8'h00, 16'hC010, 21'h3C010, 1'b1, 8'd4},  // R4 switched 32K
        '{8'h01, 8'h00, 16'hA001, 21'h2A001, 1'b1, 8'd5},  // R5 low 16K
        '{8'h01, 8'h00, 16'hD555, 21'h7D555, 1'b1, 8'd5},  // R5 fixed top 16K
        '{8'h05, 8'h00, 16'hE002, 21'h5E002, 1'b1, 8'd5},  // R5 switched top
        '{8'h02, 8'h00, 16'h8100, 21'h0A100, 1'b1, 8'd6},  // R6 window 8000
        '{8'h02, 8'h00, 16'hB00F, 21'h5500F, 1'b1, 8'd6},  // R6 window A000
        '{8'h03, 8'h00, 16'hC0F0, 21'h260F0, 1'b1, 8'd6},  // R6 code 3 C000
        '{8'h03, 8'h00, 16'hFFFF, 21'h7FFFF, 1'b1, 8'd10}, // R10 code 3 top
        '{8'h07, 8'h00, 16'hE800, 21'h6E800, 1'b1, 8'd6},  // R6 code 7 top
        '{8'h06, 8'h00, 16'hF000, 21'h6F000, 1'b1, 8'd6},  // R6 code 6 top
        '{8'h80, 8'h00, 16'h6ABC, 21'h3EABC, 1'b1, 8'd7},  // R7 32K low window
        '{8'h81, 8'h00, 16'h7001, 21'h5F001, 1'b1, 8'd7},  // R7 16K low window
        '{8'h86, 8'h00, 16'h6000, 21'h6E000, 1'b1, 8'd7},  // R7 8K low window
        '{8'h02, 8'h00, 16'h6000, 21'h00000, 1'b0, 8'd3},  // R3 low window off
        '{8'h00, 8'h00, 16'h5FFF, 21'h00000, 1'b0, 8'd2},  // R2 below 6000
        '{8'h00, 8'h06, 16'h8000, 21'h1F8000, 1'b1, 8'd8}, // R8 segment 3
        '{8'h02, 8'h02, 16'h8000, 21'h08A000, 1'b1, 8'd8}, // R8 segment 1
        '{8'h81, 8'h04, 16'h6000, 21'h15E000, 1'b1, 8'd8}, // R8 segment 2 low
        '{8'h01, 8'h04, 16'hC000, 21'h17C000, 1'b1, 8'd10},// R10 with segment
        '{8'h00, 8'hF9, 16'h9234, 21'h79234, 1'b1, 8'd8},  // R8 other bits ignored
        '{8'h7A, 8'h00, 16'h8100, 21'h0A100, 1'b1, 8'd9}   // R9 ctrl [6:3] ignored
    };

    task automatic put(input int kind, input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        bank_wr  = (kind == 0);
        ctrl_wr  = (kind == 1);
        outer_wr = (kind == 2);
        wr_idx   = idx;
        wr_data  = d;
        @(negedge clk);
        bank_wr = 1'b0; ctrl_wr = 1'b0; outer_wr = 1'b0;
    endtask

    task automatic probe(input string tag, input logic [15:0] a,
                         input logic [20:0] ea, input logic es);
        cpu_addr = a;
        #1;
        n_checks++;
        if (rom_addr !== ea || rom_sel !== es) begin
            n_err++;
            $display("FAIL %s addr=%h actual rom_addr=%h sel=%b expected rom_addr=%h sel=%b",
                     tag, a, rom_addr, rom_sel, ea, es);
        end
    endtask

    task automatic probe_flag(input string tag, input logic ef);
        #1;
        n_checks++;
        if (low_win_rom !== ef) begin
            n_err++;
            $display("FAIL %s low_win_rom actual=%b expected=%b", tag, low_win_rom, ef);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        probe("R1 reset 32K fixed", 16'h8000, 21'h78000, 1'b1);
        probe("R1 reset low window off", 16'h6000, 21'h0, 1'b0);
        probe_flag("R1 reset flag", 1'b0);
        put(1, 2'd0, 8'h02);
        probe("R1 bank regs all ones", 16'h8000, 21'h7E000, 1'b1);

        put(0, 2'd0, 8'h05);
        put(0, 2'd1, 8'h2A);
        put(0, 2'd2, 8'h13);
        put(0, 2'd3, 8'h37);
        for (int i = 0; i < NV; i++) begin
            put(1, 2'd0, VECS[i].ctrl);
            put(2, 2'd0, VECS[i].outer);
            probe($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].addr, VECS[i].exp_addr, VECS[i].exp_sel);
        end

        // R3 flag follows control bit 7
        put(1, 2'd0, 8'h80);
        probe_flag("R3 flag set", 1'b1);
        put(1, 2'd0, 8'h7F);
        probe_flag("R3 flag clear", 1'b0);

        // R9 routing and single-edge latency, code 2, segment 0
        put(2, 2'd0, 8'h00);
        put(1, 2'd0, 8'h02);
        put(0, 2'd0, 8'h11);
        probe("R9 reg0 visible after edge", 16'h8000, 21'h22000, 1'b1);
        put(0, 2'd2, 8'h00);
        probe("R9 reg2 write leaves 8000", 16'h8000, 21'h22000, 1'b1);
        probe("R9 reg2 lands at C000", 16'hC000, 21'h00000, 1'b1);
        probe("R10 code 2 top fixed", 16'hE000, 21'h7E000, 1'b1);

        // R1 reset again restores defaults
        do_reset();
        probe("R1 second reset", 16'h8000, 21'h78000, 1'b1);
        probe("R2 top of map", 16'hFFFC, 21'h7FFFC, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule